// File: doc/BRIEF.md
# Prescaled Hold PWM Generator

This block produces the pulse-width-modulated hold drive for a solenoid. It uses three programmable settings. A duty value sets how long the output stays high. A top value sets how far the PWM counter runs before it wraps. A 4-bit divider code picks a power-of-two prescale of the system clock.

The prescaled tick advances an up-counter from 0 to the top value, and the output is high while the counter is below the duty value. A load strobe captures a new setting triple. While the block runs, the new triple is held back until the counter next wraps, so the output never carries a partial or mixed period. While the enable input is low, the output stays low, the counters stay cleared, and a load takes effect at once.

The system that controls the solenoid uses the block by writing the settings once and then using the enable input to gate the hold phase.

Top module: `hold_pwm`

## Requirements
- R1: Reset is synchronous, on `rst_n` low. It sets duty 127, top 255 and divider code 5, holds `pwm_out` and `cfg_err` low, and leaves the default period at 4096 clocks with 2032 clocks high.
- R2: For divider code n from 1 to 15, one tick lasts 2^(n-1) clocks. The period is (top+1) ticks.
- R3: With duty between 1 and 254, the output is high for min(duty, top+1) ticks in each period. A duty at or above top+1, or a duty of 255, holds the output high all the time.
- R4: A duty of 0 holds the output low all the time.
- R5: A loaded divider code of 0 acts as code 1 and sets `cfg_err` one cycle after the strobe. A later load with a code from 1 to 15 clears `cfg_err`.
- R6: A load while `en` is high leaves the current period unchanged. The new settings start at the next counter wrap.
- R7: A load strobe that falls in the same cycle as a counter wrap supplies the settings for the period that begins at that wrap.
- R8: While `en` is low, `pwm_out` is low and the counters are cleared. With duty above 0, `pwm_out` is high in the cycle after the first clock edge that samples `en` high, and it starts a full period there.
- R9: A load while `en` is low takes effect at once, so the first period after enable already uses the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low forces the output low and clears the counters |
| load | input | 1 | One-cycle strobe that captures duty_in, top_in and div_in |
| duty_in | input | 8 | Duty threshold, 0 to 255 |
| top_in | input | 8 | Counter top value, 0 to 255 |
| div_in | input | 4 | Divider code; n divides by 2^(n-1), and 0 is illegal |
| pwm_out | output | 1 | Registered hold PWM output |
| cfg_err | output | 1 | High after a load with divider code 0 |

## Verification
Two events can fall in the same cycle: a load strobe and a counter wrap. The bench provokes this with divider code 1. It detects a rising edge of the output and then raises `load` exactly top-1 sample points later, so the strobe is sampled on the wrap edge itself. The check passes only if the period in progress keeps its old length and high time, and the very next period already shows the new top and duty. A second run places the strobe early in a period to show that the new values wait for that wrap.

// File: rtl/hpwm_pkg.sv
// Package: shared widths and reset defaults for the hold PWM generator.
// Assumes: divider codes fit in CODE_W bits; the prescaler spans 2^CODE_W-2 stages.
package hpwm_pkg;
    localparam int DATA_W   = 8;
    localparam int CODE_W   = 4;
    localparam int PRE_W    = (1 << CODE_W) - 2;
    localparam int RST_DUTY = 127;
    localparam int RST_TOP  = 255;
    localparam int RST_CODE = 5;
endpackage

// File: rtl/hpwm_prescale.sv
// Module: power-of-two prescaler. Emits a one-cycle tick every 2^shift clocks.
// Assumes: shift <= PRE_W; clr restarts the prescale window; en low clears it.
module hpwm_prescale #(
    parameter int CODE_W = hpwm_pkg::CODE_W,
    parameter int PRE_W  = hpwm_pkg::PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [CODE_W-1:0] shift,
    output logic              tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W:0]   mask_full;
    logic [PRE_W-1:0] mask;

    // Build the low-bit mask that marks the end of one prescale window.
    always_comb begin
        mask_full = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
        mask      = mask_full[PRE_W-1:0];
        tick      = en && ((pre_cnt & mask) == mask);
    end

    // Free-running prescale counter, cleared when idle or at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + PRE_W'(1);
    end
endmodule

// File: rtl/hpwm_counter.sv
// Module: period counter. Counts prescaled ticks from 0 to top and then wraps.
// Assumes: top may change only at a wrap or while en is low (enforced upstream).
module hpwm_counter #(
    parameter int DATA_W = hpwm_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] cnt,
    output logic              wrap
);
    // Flag the tick that ends the current period.
    always_comb wrap = tick && (cnt == top);

    // Advance on each tick, return to zero at the wrap, hold zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + DATA_W'(1);
    end

    // R2
    cnt_within_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= top);

    // R2
    cnt_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == DATA_W'($past(cnt) + DATA_W'(1))));
endmodule

// File: rtl/hpwm_compare.sv
// Module: duty comparator with a registered output stage.
// Assumes: the all-ones duty code means full on; the output is low when en is low.
module hpwm_compare #(
    parameter int DATA_W = hpwm_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] duty,
    input  logic [DATA_W-1:0] cnt,
    output logic              out_q
);
    logic above;

    // Decide the level for the counter value presently held.
    always_comb above = (duty == {DATA_W{1'b1}}) || (cnt < duty);

    // Register the level so the pin is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else
            out_q <= en && above;
    end
endmodule

// File: rtl/hold_pwm.sv
// Module: top of the hold PWM generator. Holds the pending and active
// settings, clamps the divider code, and joins prescaler, counter and comparator.
// Assumes: load is a single-cycle strobe; settings swap only at a wrap or while idle.
module hold_pwm #(
    parameter int DATA_W   = hpwm_pkg::DATA_W,
    parameter int CODE_W   = hpwm_pkg::CODE_W,
    parameter int RST_DUTY = hpwm_pkg::RST_DUTY,
    parameter int RST_TOP  = hpwm_pkg::RST_TOP,
    parameter int RST_CODE = hpwm_pkg::RST_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic [DATA_W-1:0] duty_in,
    input  logic [DATA_W-1:0] top_in,
    input  logic [CODE_W-1:0] div_in,
    output logic              pwm_out,
    output logic              cfg_err
);
    localparam logic [DATA_W-1:0] DEF_DUTY  = DATA_W'(RST_DUTY);
    localparam logic [DATA_W-1:0] DEF_TOP   = DATA_W'(RST_TOP);
    localparam logic [CODE_W-1:0] DEF_SHIFT = CODE_W'(RST_CODE - 1);

    logic [DATA_W-1:0] pend_duty, pend_top, act_duty, act_top;
    logic [CODE_W-1:0] pend_shift, act_shift, in_shift;
    logic [DATA_W-1:0] src_duty, src_top;
    logic [CODE_W-1:0] src_shift;
    logic              err_q, tick, wrap, out_q;
    logic [DATA_W-1:0] cnt;

    // Clamp the incoming divider code and turn it into a shift amount.
    always_comb begin
        in_shift  = (div_in == '0) ? '0 : div_in - CODE_W'(1);
        src_duty  = load ? duty_in  : pend_duty;
        src_top   = load ? top_in   : pend_top;
        src_shift = load ? in_shift : pend_shift;
    end

    // Capture each load strobe into the pending settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_duty  <= DEF_DUTY;
            pend_top   <= DEF_TOP;
            pend_shift <= DEF_SHIFT;
        end else if (load) begin
            pend_duty  <= duty_in;
            pend_top   <= top_in;
            pend_shift <= in_shift;
        end
    end

    // Move the settings into use at a wrap, or at once while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty  <= DEF_DUTY;
            act_top   <= DEF_TOP;
            act_shift <= DEF_SHIFT;
        end else if (!en || wrap) begin
            act_duty  <= src_duty;
            act_top   <= src_top;
            act_shift <= src_shift;
        end
    end

    // Record whether the last load carried the illegal divider code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (load)
            err_q <= (div_in == '0);
    end

    hpwm_prescale #(.CODE_W(CODE_W), .PRE_W((1 << CODE_W) - 2)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(wrap),
        .shift(act_shift), .tick(tick)
    );

    hpwm_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .top(act_top), .cnt(cnt), .wrap(wrap)
    );

    hpwm_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .en(en), .duty(act_duty),
        .cnt(cnt), .out_q(out_q)
    );

    assign pwm_out = out_q;
    assign cfg_err = err_q;

    // R6
    settings_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> ($stable(act_duty) && $stable(act_top) && $stable(act_shift)));

    // R5
    bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && div_in == '0) |=> cfg_err);

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

    // R8
    idle_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

// File: tb/hold_pwm_bench.sv
module hold_pwm_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] duty_in = '0;
    logic [7:0] top_in = '0;
    logic [3:0] div_in = 4'd1;
    logic       pwm_out, cfg_err;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    hold_pwm u_hold_pwm (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .duty_in(duty_in), .top_in(top_in), .div_in(div_in),
        .pwm_out(pwm_out), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    function automatic int exp_period(int top, int code);
        int c = (code == 0) ? 1 : code;
        return (top + 1) << (c - 1);
    endfunction

    function automatic int exp_high(int duty, int top, int code);
        int c = (code == 0) ? 1 : code;
        int t;
        if (duty == 255) t = top + 1;
        else t = (duty < top + 1) ? duty : top + 1;
        return t << (c - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Load settings while idle, then enable; returns on the first enabled sample.
    task automatic cfg(input int duty, input int top, input int code);
        @(negedge clk);
        en = 1'b0; load = 1'b1;
        duty_in = 8'(duty); top_in = 8'(top); div_in = 4'(code);
        @(negedge clk);
        load = 1'b0;
        check(pwm_out == 1'b0, "R8 low while idle", int'(pwm_out), 0);
        en = 1'b1;
        @(negedge clk);
        if (duty != 0)
            check(pwm_out == 1'b1, "R8 high one cycle after enable", int'(pwm_out), 1);
    endtask

    // From a rising-edge sample, count the period and high samples until the next rise.
    task automatic run_period(input int load_at, input int nd, input int nt, input int nc,
                              output int cyc, output int hi);
        bit prev = 1'b1;
        cyc = 1; hi = 1;
        for (int k = 0; k < 40000; k++) begin
            if (k == load_at) begin
                load = 1'b1; duty_in = 8'(nd); top_in = 8'(nt); div_in = 4'(nc);
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
            if (pwm_out && !prev) return;
            cyc++;
            if (pwm_out) hi++;
            prev = pwm_out;
        end
    endtask

    task automatic check_const(input bit val, input int n, input string req);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out != val) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic run_case(input int duty, input int top, input int code, input string req);
        int p = exp_period(top, code);
        int h = exp_high(duty, top, code);
        int cyc, hi;
        cfg(duty, top, code);
        if (h == 0) begin
            check(pwm_out == 1'b0, {req, " R4 duty 0 low"}, int'(pwm_out), 0);
            check_const(1'b0, 2 * p, {req, " R4 stays low"});
        end else if (h == p) begin
            check_const(1'b1, 2 * p, {req, " R3 full on"});
        end else begin
            run_period(-1, 0, 0, 0, cyc, hi);
            check(cyc == p, {req, " R2 period"}, cyc, p);
            check(hi == h, {req, " R3 high time"}, hi, h);
        end
    endtask

    initial begin
        int cyc, hi, seed;
        seed = int'($urandom(32'd2024));

        // R1: reset state and defaults
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1 pwm low in reset", int'(pwm_out), 0);
        check(cfg_err == 1'b0, "R1 err low in reset", int'(cfg_err), 0);
        rst_n = 1'b1; en = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b1, "R1 output starts high", int'(pwm_out), 1);
        run_period(-1, 0, 0, 0, cyc, hi);
        check(cyc == 4096, "R1 default period", cyc, 4096);
        check(hi == 2032, "R1 default high time", hi, 2032);

        // R8: disabled output held low
        @(negedge clk); en = 1'b0;
        check_const(1'b0, 40, "R8 held low while disabled");

        // R9, R2, R3: directed patterns (settings loaded while idle)
        run_case(7, 7, 2, "R9 duty equals top");
        run_case(200, 50, 1, "R3 duty above top");
        run_case(255, 255, 1, "R3 duty 255");
        run_case(0, 10, 3, "R4");
        run_case(1, 0, 1, "R3 top 0");

        // R5: illegal divider code clamps to 1 and flags
        cfg(2, 3, 0);
        check(cfg_err == 1'b1, "R5 flag on code 0", int'(cfg_err), 1);
        run_period(-1, 0, 0, 0, cyc, hi);
        check(cyc == 4, "R5 clamped period", cyc, 4);
        check(hi == 2, "R5 clamped high", hi, 2);
        cfg(1, 1, 12);
        check(cfg_err == 1'b0, "R5 flag cleared", int'(cfg_err), 0);
        run_period(-1, 0, 0, 0, cyc, hi);
        check(cyc == 4096, "R2 code 12 period", cyc, 4096);
        check(hi == 2048, "R2 code 12 high", hi, 2048);

        // R6: load mid-period waits for the wrap
        cfg(5, 9, 1);
        run_period(2, 1, 3, 2, cyc, hi);
        check(cyc == 10, "R6 old period kept", cyc, 10);
        check(hi == 5, "R6 old high kept", hi, 5);
        run_period(-1, 0, 0, 0, cyc, hi);
        check(cyc == 8, "R6 new period", cyc, 8);
        check(hi == 2, "R6 new high", hi, 2);

        // R7: load on the wrap cycle itself
        cfg(3, 7, 1);
        run_period(6, 2, 4, 1, cyc, hi);
        check(cyc == 8, "R7 old period at coincidence", cyc, 8);
        check(hi == 3, "R7 old high at coincidence", hi, 3);
        run_period(-1, 0, 0, 0, cyc, hi);
        check(cyc == 5, "R7 new period from wrap", cyc, 5);
        check(hi == 2, "R7 new high from wrap", hi, 2);

        // Random combinations, R2 and R3
        for (int i = 0; i < 12; i++) begin
            int d = int'($urandom % 256);
            int t = int'($urandom % 256);
            int c = 1 + int'($urandom % 4);
            run_case(d, t, c, "R2 R3 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule